// File: doc/BRIEF.md
# PCIe Interrupt Status Aggregator

This block gathers the four legacy level-sensitive interrupt wires of a PCIe root port and the message-signalled interrupts that arrive as inbound 32-bit memory writes. It merges them into a single interrupt line for a CPU. An inbound write counts as a message interrupt when its address equals a programmable target address. Its data value then names one of 32 vectors, and that vector's pending bit is set.

Status has two levels. The 32 per-vector pending bits are collected in a vector register. Any pending vector raises a summary bit in the top status word, which also holds four legacy bits. A mask register has bits at the same positions as the top status word. Software reads the top status word. For message interrupts it rereads the vector register and clears bits by writing ones until the register reads zero, then clears the summary bit.

The register bus is a plain word interface. The read data is combinational on the address and a write takes effect on the clock edge where the write strobe is high. Byte offsets: 0x0 top status, 0x4 mask, 0x8 vector pending, 0xC target address. Any other word reads zero.

Top module: `pcie_irq_aggregator`

## Requirements
- R1: After reset the top status and vector registers read 0, the target address reads 0, the mask reads 0x008F0000 (all sources disabled), and `irq_o` is 0.
- R2: When `msi_valid_i` is high, `msi_addr_i` equals the full 32-bit target address and `msi_data_i` is below 32, vector bit `msi_data_i` reads 1 at offset 0x8 from the next clock. Message addresses have no upper half: only 32-bit addresses are compared.
- R3: Writing offset 0x8 clears each vector bit whose write-data bit is 1 and leaves the other bits unchanged.
- R4: The target address at offset 0xC is a 32-bit read/write register, and its current value is the one used for matching.
- R5: Top status bit 23 is set one clock after any vector bit is pending. Writing 1 to bit 23 clears it only when no vector bit is pending; otherwise it stays 1.
- R6: Top status bits 19:16 (INTA..INTD = `intx_i[0..3]`) are set one clock after the matching input is high. Writing 1 clears a bit only while its input is low.
- R7: A message write whose data is 32 or more, or whose address differs from the target, changes no vector bit.
- R8: Only mask bits 19:16 and 23 are stored; all other mask bits read 0. `irq_o` is 1 exactly when some top status bit among 19:16 and 23 is 1 and its mask bit is 0.
- R9: When a hardware set and a software write-1 clear reach the same status bit in the same clock, the bit ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr_i | input | 4 | Register byte address |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on address) |
| msi_valid_i | input | 1 | Inbound memory write present |
| msi_addr_i | input | 32 | Inbound write address |
| msi_data_i | input | 32 | Inbound write data (vector number) |
| intx_i | input | 4 | Legacy interrupt levels, INTA..INTD |
| irq_o | output | 1 | Combined CPU interrupt |

## Verification
A vector bit and a legacy status bit become visible one clock after their stimulus. The summary bit follows the vector register one clock later, so it is due two clocks after the inbound write. `irq_o` and the read data depend only on the registers and the address, so they change in the same cycle as the status they reflect. The bench drives inputs shortly after the falling edge and updates its reference model on the rising edge. It compares read data and `irq_o` at every falling edge, and it samples each directed check after the number of edges listed above.

// File: rtl/pia_pkg.sv
package pia_pkg;
  localparam int unsigned NUM_VEC     = 32;
  localparam int unsigned NUM_INTX    = 4;
  localparam int unsigned INTX_LSB    = 16;
  localparam int unsigned SUM_BIT     = 23;
  localparam int unsigned WIDX_STATUS = 0;
  localparam int unsigned WIDX_MASK   = 1;
  localparam int unsigned WIDX_VEC    = 2;
  localparam int unsigned WIDX_TARGET = 3;
endpackage

// File: rtl/pia_w1c_bank.sv
module pia_w1c_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_d;
  logic         en;

  always_comb begin
    en  = |(set_i | clr_i);
    q_d = (q_o & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_o <= '0;
    else if (en) q_o <= q_d;
  end

  // R9: a set bit is 1 after the edge even if cleared in the same cycle
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((q_o & $past(set_i)) == $past(set_i)));

  // R3: a cleared bit without a set is 0 after the edge
  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~set_i)) |=> ((q_o & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/pia_msi_decode.sv
module pia_msi_decode #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  parameter int unsigned NV = 32
) (
  input  logic          valid_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic [AW-1:0] target_i,
  output logic [NV-1:0] set_o
);
  localparam int unsigned VW = $clog2(NV);

  logic hit;

  always_comb begin
    hit = valid_i && (addr_i == target_i) && (data_i < DW'(NV));
  end

  for (genvar i = 0; i < NV; i++) begin : g_vec
    assign set_o[i] = hit && (data_i[VW-1:0] == VW'(i));
  end
endmodule

// File: rtl/pia_ctrl_regs.sv
module pia_ctrl_regs #(
  parameter int unsigned AW = 32,
  parameter int unsigned MW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mask_we_i,
  input  logic [MW-1:0] mask_wdata_i,
  input  logic          tgt_we_i,
  input  logic [AW-1:0] tgt_wdata_i,
  output logic [MW-1:0] mask_o,
  output logic [AW-1:0] tgt_o
);
  logic [MW-1:0] mask_d;
  logic [AW-1:0] tgt_d;

  always_comb begin
    mask_d = mask_we_i ? mask_wdata_i : mask_o;
    tgt_d  = tgt_we_i  ? tgt_wdata_i  : tgt_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mask_o <= '1;
    else if (mask_we_i) mask_o <= mask_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tgt_o <= '0;
    else if (tgt_we_i) tgt_o <= tgt_d;
  end

  // R4: a target write lands unchanged
  assert_tgt_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_we_i |=> (tgt_o == $past(tgt_wdata_i)));
endmodule

// File: rtl/pcie_irq_aggregator.sv
module pcie_irq_aggregator
  import pia_pkg::*;
#(
  parameter int unsigned REG_AW = 4,
  parameter int unsigned DW     = 32,
  parameter int unsigned MSI_AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  input  logic              msi_valid_i,
  input  logic [MSI_AW-1:0] msi_addr_i,
  input  logic [DW-1:0]     msi_data_i,
  input  logic [NUM_INTX-1:0] intx_i,
  output logic              irq_o
);
  localparam int unsigned WW = REG_AW - 2;
  localparam int unsigned MW = NUM_INTX + 1;

  logic [1:0]          rst_sync;
  logic                rst_int_n;
  logic [WW-1:0]       widx;
  logic                wr_stat, wr_mask, wr_vec, wr_tgt;
  logic [NUM_VEC-1:0]  vec_set, vec_q;
  logic [NUM_INTX-1:0] intx_q;
  logic                sum_q;
  logic [MW-1:0]       mask_q, mask_wr;
  logic [MSI_AW-1:0]   tgt_q;
  logic [DW-1:0]       stat_word, mask_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  always_comb begin
    widx    = reg_addr_i[REG_AW-1:2];
    wr_stat = reg_we_i && (widx == WW'(WIDX_STATUS));
    wr_mask = reg_we_i && (widx == WW'(WIDX_MASK));
    wr_vec  = reg_we_i && (widx == WW'(WIDX_VEC));
    wr_tgt  = reg_we_i && (widx == WW'(WIDX_TARGET));
    mask_wr = {reg_wdata_i[SUM_BIT], reg_wdata_i[INTX_LSB +: NUM_INTX]};
  end

  pia_msi_decode #(.AW(MSI_AW), .DW(DW), .NV(NUM_VEC)) i_decode (
    .valid_i  (msi_valid_i),
    .addr_i   (msi_addr_i),
    .data_i   (msi_data_i),
    .target_i (tgt_q),
    .set_o    (vec_set)
  );

  pia_w1c_bank #(.W(NUM_VEC)) i_vec_bank (
    .clk   (clk),
    .rst_n (rst_int_n),
    .set_i (vec_set),
    .clr_i (wr_vec ? reg_wdata_i[NUM_VEC-1:0] : '0),
    .q_o   (vec_q)
  );

  pia_w1c_bank #(.W(NUM_INTX)) i_intx_bank (
    .clk   (clk),
    .rst_n (rst_int_n),
    .set_i (intx_i),
    .clr_i (wr_stat ? reg_wdata_i[INTX_LSB +: NUM_INTX] : '0),
    .q_o   (intx_q)
  );

  pia_w1c_bank #(.W(1)) i_sum_bank (
    .clk   (clk),
    .rst_n (rst_int_n),
    .set_i (|vec_q),
    .clr_i (wr_stat && reg_wdata_i[SUM_BIT]),
    .q_o   (sum_q)
  );

  pia_ctrl_regs #(.AW(MSI_AW), .MW(MW)) i_ctrl (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .mask_we_i    (wr_mask),
    .mask_wdata_i (mask_wr),
    .tgt_we_i     (wr_tgt),
    .tgt_wdata_i  (reg_wdata_i[MSI_AW-1:0]),
    .mask_o       (mask_q),
    .tgt_o        (tgt_q)
  );

  always_comb begin
    stat_word = '0;
    stat_word[INTX_LSB +: NUM_INTX] = intx_q;
    stat_word[SUM_BIT]              = sum_q;
    mask_word = '0;
    mask_word[INTX_LSB +: NUM_INTX] = mask_q[NUM_INTX-1:0];
    mask_word[SUM_BIT]              = mask_q[NUM_INTX];
    case (widx)
      WW'(WIDX_STATUS): reg_rdata_o = stat_word;
      WW'(WIDX_MASK):   reg_rdata_o = mask_word;
      WW'(WIDX_VEC):    reg_rdata_o = DW'(vec_q);
      WW'(WIDX_TARGET): reg_rdata_o = DW'(tgt_q);
      default:          reg_rdata_o = '0;
    endcase
    irq_o = (|(intx_q & ~mask_q[NUM_INTX-1:0])) | (sum_q & ~mask_q[NUM_INTX]);
  end

  // R5: a pending vector keeps the summary bit set on the next edge
  assert_summary_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (|vec_q) |=> sum_q);

  // R6: a high legacy level is reported on the next edge
  assert_intx_follow_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (|intx_i) |=> ((intx_q & $past(intx_i)) == $past(intx_i)));

  // R7: out-of-range vector numbers set nothing
  assert_bad_data_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (msi_valid_i && (msi_data_i >= DW'(NUM_VEC))) |=> ((vec_q & ~$past(vec_q)) == '0));

  // R7: non-matching addresses set nothing
  assert_bad_addr_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (msi_valid_i && (msi_addr_i != tgt_q)) |=> ((vec_q & ~$past(vec_q)) == '0));

  // R2: a matching write sets its vector
  assert_msi_set_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (msi_valid_i && (msi_addr_i == tgt_q) && (msi_data_i < DW'(NUM_VEC)))
      |=> vec_q[$past(msi_data_i[4:0])]);
endmodule

// File: tb/test_pcie_irq_aggregator.sv
`timescale 1ns/1ps
module test_pcie_irq_aggregator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        msi_valid = 1'b0;
  logic [31:0] msi_addr = '0;
  logic [31:0] msi_data = '0;
  logic [3:0]  intx = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // reference model state
  logic [31:0] m_vec = '0;
  logic        m_sum = 1'b0;
  logic [3:0]  m_intx = '0;
  logic [31:0] m_mask = 32'h008F_0000;
  logic [31:0] m_tgt = '0;

  always #2.5 clk = ~clk;

  pcie_irq_aggregator i_pcie_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .reg_addr_i(reg_addr), .reg_we_i(reg_we),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .msi_valid_i(msi_valid),
    .msi_addr_i(msi_addr), .msi_data_i(msi_data), .intx_i(intx), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [3:0] a);
    logic [31:0] s;
    s = '0;
    s[19:16] = m_intx;
    s[23]    = m_sum;
    case (a[3:2])
      2'd0: return s;
      2'd1: return m_mask;
      2'd2: return m_vec;
      default: return m_tgt;
    endcase
  endfunction

  function automatic logic m_irq();
    return (|(m_intx & ~m_mask[19:16])) | (m_sum & ~m_mask[23]);
  endfunction

  always @(posedge clk) begin
    logic        hit;
    logic [31:0] clr_vec;
    logic        clr_sum;
    logic [3:0]  clr_intx;
    logic [31:0] n_vec;
    if (rst_n) begin
      hit      = msi_valid && (msi_addr == m_tgt) && (msi_data < 32);
      clr_vec  = (reg_we && reg_addr[3:2] == 2'd2) ? reg_wdata : 32'h0;
      clr_sum  = reg_we && reg_addr[3:2] == 2'd0 && reg_wdata[23];
      clr_intx = (reg_we && reg_addr[3:2] == 2'd0) ? reg_wdata[19:16] : 4'h0;
      n_vec    = m_vec & ~clr_vec;
      if (hit) n_vec[msi_data[4:0]] = 1'b1;
      m_sum  = (m_sum & ~clr_sum) | (m_vec != 0);
      m_vec  = n_vec;
      m_intx = (m_intx & ~clr_intx) | intx;
      if (reg_we && reg_addr[3:2] == 2'd1) m_mask = reg_wdata & 32'h008F_0000;
      if (reg_we && reg_addr[3:2] == 2'd3) m_tgt = reg_wdata;
    end
  end

  always @(negedge clk) begin
    cycles++;
    chk("R8 model rdata", reg_rdata, m_read(reg_addr));
    chk("R8 model irq", {31'b0, irq}, {31'b0, m_irq()});
  end

  task automatic idle();
    @(negedge clk); #1;
    reg_we = 1'b0; msi_valid = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    reg_addr = a; reg_wdata = d; reg_we = 1'b1; msi_valid = 1'b0;
  endtask

  task automatic msi(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    reg_we = 1'b0; msi_valid = 1'b1; msi_addr = a; msi_data = d;
  endtask

  // read after the pending edges have settled
  task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
    @(negedge clk); #1;
    reg_we = 1'b0; msi_valid = 1'b0; reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
  end

  initial begin
    logic [31:0] tgt;
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd_chk("R1 status", 4'h0, 32'h0);
    rd_chk("R1 mask", 4'h4, 32'h008F_0000);
    rd_chk("R1 vec", 4'h8, 32'h0);
    rd_chk("R1 target", 4'hC, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    tgt = 32'h1234_5670;
    wr(4'hC, tgt);
    rd_chk("R4 target readback", 4'hC, tgt);

    msi(tgt, 32'd5);
    rd_chk("R2 vector 5 set", 4'h8, 32'h0000_0020);
    rd_chk("R5 summary set", 4'h0, 32'h0080_0000);
    chk("R8 masked irq low", {31'b0, irq}, 32'h0);

    msi(tgt, 32'd40);
    rd_chk("R7 data 40 ignored", 4'h8, 32'h0000_0020);
    msi(tgt ^ 32'h4, 32'd3);
    rd_chk("R7 address mismatch ignored", 4'h8, 32'h0000_0020);

    wr(4'h4, 32'hFFFF_FFFF);
    rd_chk("R8 mask implemented bits only", 4'h4, 32'h008F_0000);
    wr(4'h4, 32'h0);
    rd_chk("R8 mask cleared", 4'h4, 32'h0);
    chk("R8 irq from summary", {31'b0, irq}, 32'h1);

    wr(4'h0, 32'h0080_0000);
    rd_chk("R5 summary stays while pending", 4'h0, 32'h0080_0000);
    wr(4'h8, 32'h0000_0001);
    rd_chk("R3 write 1 to other bit keeps bit 5", 4'h8, 32'h0000_0020);
    wr(4'h8, 32'h0000_0020);
    rd_chk("R3 vector 5 cleared", 4'h8, 32'h0);
    wr(4'h0, 32'h0080_0000);
    rd_chk("R5 summary cleared", 4'h0, 32'h0);
    chk("R8 irq low after service", {31'b0, irq}, 32'h0);

    msi(tgt, 32'd31);
    @(negedge clk); #1;
    reg_addr = 4'h8; reg_wdata = 32'h8000_0000; reg_we = 1'b1;
    msi_valid = 1'b1; msi_addr = tgt; msi_data = 32'd31;
    rd_chk("R9 set beats clear", 4'h8, 32'h8000_0000);
    wr(4'h8, 32'h8000_0000);
    idle();
    wr(4'h0, 32'h0080_0000);

    @(negedge clk); #1 intx = 4'b0100;
    rd_chk("R6 INTC reported", 4'h0, 32'h0004_0000);
    wr(4'h0, 32'h000F_0000);
    rd_chk("R6 held level resets bit", 4'h0, 32'h0004_0000);
    @(negedge clk); #1 intx = 4'b0000;
    wr(4'h0, 32'h0004_0000);
    rd_chk("R6 cleared after drop", 4'h0, 32'h0);

    @(negedge clk); #1 intx = 4'b0001;
    wr(4'h4, 32'h000F_0000);
    rd_chk("R8 INTA masked", 4'h0, 32'h0001_0000);
    chk("R8 masked INTA gives no irq", {31'b0, irq}, 32'h0);
    wr(4'h4, 32'h008E_0000);
    idle();
    chk("R8 unmasked INTA irq", {31'b0, irq}, 32'h1);
    @(negedge clk); #1 intx = 4'b0000;

    for (int n = 0; n < 3000; n++) begin
      @(negedge clk); #1;
      msi_valid = ($urandom_range(0, 2) == 0);
      msi_addr  = ($urandom_range(0, 3) == 0) ? (m_tgt ^ 32'h10) : m_tgt;
      msi_data  = $urandom_range(0, 47);
      reg_addr  = 4'($urandom_range(0, 15));
      reg_we    = ($urandom_range(0, 3) == 0) && (reg_addr[3:2] != 2'd3);
      reg_wdata = $urandom();
      if ($urandom_range(0, 7) == 0) intx = 4'($urandom_range(0, 15));
    end
    idle();
    idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected<150000", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule